// File: doc/BRIEF.md
# Edge-Selective Confirmation Delay

This block passes a single-bit level to its output, but holds back one edge direction until the input has stayed at its new level for a programmable number of clock cycles. The other edge direction passes straight through. In on-delay mode the rising edge is the held edge: a high input must persist before the output goes high, and a low input clears the output at once. In off-delay mode the roles swap: a low input must persist before the output goes low, and a high input sets the output at once. It suits debouncing of a signal in one direction only, or confirming a condition before acting on it while withdrawing at once.

A start-up setting gives the input level assumed before the first clock. If that level already equals the current input level, nothing counts as an edge. The level present at start-up is then passed through without waiting. The output is registered, so every "immediate" response shows up after the next rising clock edge.

Top module: `edge_confirm`

## Requirements
- R1: With `mode` = 0 (on-delay) and `delay` = D > 0, suppose `din` is sampled low at one clock edge and then high at edge E0 and every edge after it. Then `dout` stays 0 through edge E0+D-1, becomes 1 after edge E0+D, and stays 1 while `din` stays high.
- R2: With `mode` = 0, `din` sampled low at an edge makes `dout` 0 after that same edge, with no delay.
- R3: With `mode` = 1 (off-delay) and `delay` = D > 0, suppose `din` is sampled high and then low at edge E0 and every edge after it. Then `dout` stays 1 through edge E0+D-1, becomes 0 after edge E0+D, and stays 0 while `din` stays low.
- R4: With `mode` = 1, `din` sampled high at an edge makes `dout` 1 after that same edge.
- R5: With `mode` = 0 and `init_prev` = 1, a `din` that is already high when reset is released makes `dout` 1 with no delay. With `init_prev` = 0, the same input is treated as a rising edge and is delayed as in R1.
- R6: With `mode` = 1 and `init_prev` = 0, a `din` that is already low when reset is released keeps `dout` at 0 with no delay. With `init_prev` = 1, it is treated as a falling edge and is delayed as in R3.
- R7: If `din` returns to its former level before the held edge completes, including in the very cycle the count would finish, the pending change is dropped and `dout` does not change. A later edge counts again from zero.
- R8: With `delay` = 0, `dout` follows `din` one clock later in both modes.
- R9: `mode` and `delay` are taken from the ports only while no count is running. Changes made during a count take effect only after that count ends.
- R10: While `rst` is high at a clock edge, `dout` is loaded with `init_prev` and any running count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Level to be confirmed |
| mode | input | 1 | 0 = on-delay (rising edge held), 1 = off-delay (falling edge held) |
| delay | input | CNT_W | Hold time of the delayed edge, in clock cycles |
| init_prev | input | 1 | Input level assumed before the first sample after reset |
| dout | output | 1 | Confirmed level, registered |

## Verification
Two actions can fall on the same clock edge: completion of the count and withdrawal of the input. The bench provokes this by holding the input at the delayed level for exactly D samples and then returning it on the sample where the count would finish. The output must stay at its old level, and a pulse one sample longer must get through. A second collision is a configuration change made on the cycle after a count starts. The bench judges it by the output rising at the original delay rather than the new one.

// File: rtl/edge_confirm_pkg.sv
`timescale 1ns/1ps
package edge_confirm_pkg;

  // Which input edge is held back.
  typedef enum logic {
    HOLD_RISE = 1'b0,   // on-delay
    HOLD_FALL = 1'b1    // off-delay
  } hold_mode_e;

  // Level that the held edge moves toward.
  function automatic logic target_level(input hold_mode_e m);
    return (m == HOLD_RISE);
  endfunction

endpackage

// File: rtl/edge_confirm_cfg.sv
`timescale 1ns/1ps
// Holds mode and delay steady while a count runs.
module edge_confirm_cfg
  import edge_confirm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  hold_mode_e       mode_in,
  input  logic [CNT_W-1:0] delay_in,
  output hold_mode_e       mode_eff,
  output logic [CNT_W-1:0] delay_eff
);

  hold_mode_e       mode_q;
  logic [CNT_W-1:0] delay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= HOLD_RISE;
      delay_q <= '0;
    end else if (!busy) begin
      mode_q  <= mode_in;
      delay_q <= delay_in;
    end
  end

  // Live values while idle, frozen copies while counting.
  always_comb begin
    mode_eff  = busy ? mode_q  : mode_in;
    delay_eff = busy ? delay_q : delay_in;
  end

endmodule

// File: rtl/edge_confirm_detect.sv
`timescale 1ns/1ps
// Remembers the previous input sample and flags a move to the held level.
module edge_confirm_detect
  import edge_confirm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic       init_prev,
  input  hold_mode_e mode_eff,
  output logic       at_target,
  output logic       prev_at_target,
  output logic       hold_edge
);

  logic prev_q;
  logic tgt;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= init_prev;
    else     prev_q <= din;
  end

  always_comb begin
    tgt            = target_level(mode_eff);
    at_target      = (din == tgt);
    prev_at_target = (prev_q == tgt);
    hold_edge      = at_target && !prev_at_target;
  end

endmodule

// File: rtl/edge_confirm_cnt.sv
`timescale 1ns/1ps
// Counts cycles spent at the held level, with abort and completion.
module edge_confirm_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             at_target,
  input  logic [CNT_W-1:0] limit,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  always_comb begin
    last = (cnt_q == (limit - ONE));
    done = busy_q && at_target && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (!at_target || last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + ONE;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy  = busy_q;
  assign count = cnt_q;

endmodule

// File: rtl/edge_confirm.sv
`timescale 1ns/1ps
module edge_confirm
  import edge_confirm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             mode,
  input  logic [CNT_W-1:0] delay,
  input  logic             init_prev,
  output logic             dout
);

  hold_mode_e       cfg_mode;
  logic [CNT_W-1:0] cfg_delay;
  logic             busy;
  logic             done;
  logic [CNT_W-1:0] cnt_val;
  logic             at_target;
  logic             prev_at_target;
  logic             hold_edge;
  logic             zero_delay;
  logic             start;
  logic             tgt;
  logic             dout_q;

  edge_confirm_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mode_in   (hold_mode_e'(mode)),
    .delay_in  (delay),
    .mode_eff  (cfg_mode),
    .delay_eff (cfg_delay)
  );

  edge_confirm_detect u_detect (
    .clk            (clk),
    .rst            (rst),
    .din            (din),
    .init_prev      (init_prev),
    .mode_eff       (cfg_mode),
    .at_target      (at_target),
    .prev_at_target (prev_at_target),
    .hold_edge      (hold_edge)
  );

  always_comb begin
    tgt        = target_level(cfg_mode);
    zero_delay = (cfg_delay == '0);
    start      = !busy && hold_edge && !zero_delay;
  end

  edge_confirm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .at_target (at_target),
    .limit     (cfg_delay),
    .busy      (busy),
    .done      (done),
    .count     (cnt_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= init_prev;
    end else if (!at_target) begin
      dout_q <= !tgt;                       // unheld edge: pass at once
    end else if (done) begin
      dout_q <= tgt;                        // held edge confirmed
    end else if (!busy && (prev_at_target || zero_delay)) begin
      dout_q <= tgt;                        // level already present, or no hold
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/edge_confirm_chk.sv
`timescale 1ns/1ps
module edge_confirm_chk
  import edge_confirm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             din,
  input logic             mode,
  input logic [CNT_W-1:0] delay,
  input logic             dout,
  input logic             busy,
  input hold_mode_e       cfg_mode,
  input logic [CNT_W-1:0] cfg_delay,
  input logic [CNT_W-1:0] cnt_val
);

  // R2
  on_drop_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && mode == 1'b0 && !din) |=> !dout);

  // R4
  off_raise_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && mode == 1'b1 && din) |=> dout);

  // R1
  on_wait_low_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_mode == HOLD_RISE) |-> !dout);

  // R3
  off_wait_high_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_mode == HOLD_FALL) |-> dout);

  // R8
  zero_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && delay == '0) |=> (dout == $past(din)));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_val < cfg_delay));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cfg_delay) && $stable(cfg_mode)));

endmodule

bind edge_confirm edge_confirm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .din       (din),
  .mode      (mode),
  .delay     (delay),
  .dout      (dout),
  .busy      (busy),
  .cfg_mode  (cfg_mode),
  .cfg_delay (cfg_delay),
  .cnt_val   (cnt_val)
);

// File: tb/edge_confirm_bench.sv
`timescale 1ns/1ps
module edge_confirm_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             din = 1'b0;
  logic             mode = 1'b0;
  logic [CNT_W-1:0] delay = '0;
  logic             init_prev = 1'b0;
  logic             dout;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  edge_confirm #(.CNT_W(CNT_W)) u_edge_confirm (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .mode      (mode),
    .delay     (delay),
    .init_prev (init_prev),
    .dout      (dout)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, dout, exp, $time);
    end
  endtask

  task automatic do_reset(input logic m, input int d, input logic ip, input logic level);
    @(negedge clk);
    rst = 1'b1; mode = m; delay = CNT_W'(d); init_prev = ip; din = level;
    tick(1);
    rst = 1'b0;
    chk(ip, "R10 reset load");
  endtask

  // R1, R2
  task automatic t_on_delay();
    do_reset(1'b0, 3, 1'b0, 1'b0);
    tick(2); chk(1'b0, "R2 idle low");
    din = 1'b1;
    tick(3); chk(1'b0, "R1 before delay");
    tick(1); chk(1'b1, "R1 after delay");
    tick(5); chk(1'b1, "R1 hold high");
    din = 1'b0;
    tick(1); chk(1'b0, "R2 immediate low");
  endtask

  // R7
  task automatic t_abort();
    do_reset(1'b0, 3, 1'b0, 1'b0);
    din = 1'b1; tick(1); din = 1'b0; tick(1);
    chk(1'b0, "R7 short pulse");
    din = 1'b1; tick(3); din = 1'b0;
    tick(1); chk(1'b0, "R7 drop on completion cycle");
    tick(4); chk(1'b0, "R7 no late change");
    din = 1'b1;
    tick(3); chk(1'b0, "R7 restart from zero");
    tick(1); chk(1'b1, "R7 full count passes");
  endtask

  // R3, R4
  task automatic t_off_delay();
    do_reset(1'b1, 4, 1'b1, 1'b1);
    din = 1'b0;
    tick(4); chk(1'b1, "R3 before delay");
    tick(1); chk(1'b0, "R3 after delay");
    tick(3); chk(1'b0, "R3 hold low");
    din = 1'b1;
    tick(1); chk(1'b1, "R4 immediate high");
  endtask

  // R5
  task automatic t_init_on();
    do_reset(1'b0, 6, 1'b1, 1'b1);
    tick(1); chk(1'b1, "R5 init 1 passes at once");
    tick(5); chk(1'b1, "R5 stays high");
    do_reset(1'b0, 6, 1'b0, 1'b1);
    tick(6); chk(1'b0, "R5 init 0 waits");
    tick(1); chk(1'b1, "R5 init 0 after delay");
  endtask

  // R6
  task automatic t_init_off();
    do_reset(1'b1, 6, 1'b0, 1'b0);
    tick(1); chk(1'b0, "R6 init 0 low at once");
    tick(4); chk(1'b0, "R6 stays low");
    do_reset(1'b1, 6, 1'b1, 1'b0);
    tick(6); chk(1'b1, "R6 init 1 waits");
    tick(1); chk(1'b0, "R6 init 1 after delay");
  endtask

  // R8
  task automatic t_zero();
    do_reset(1'b0, 0, 1'b0, 1'b0);
    din = 1'b1; tick(1); chk(1'b1, "R8 on rise follows");
    din = 1'b0; tick(1); chk(1'b0, "R8 on fall follows");
    mode = 1'b1;
    din = 1'b1; tick(1); chk(1'b1, "R8 off rise follows");
    din = 1'b0; tick(1); chk(1'b0, "R8 off fall follows");
  endtask

  // R9
  task automatic t_cfg_freeze();
    do_reset(1'b0, 5, 1'b0, 1'b0);
    din = 1'b1;
    tick(1);
    delay = CNT_W'(1); mode = 1'b1;
    tick(4); chk(1'b0, "R9 old delay still running");
    tick(1); chk(1'b1, "R9 old delay completes");
    tick(1); chk(1'b1, "R9 new mode keeps high");
    mode = 1'b0; delay = CNT_W'(2);
    din = 1'b0; tick(1); chk(1'b0, "R9 idle change taken");
    din = 1'b1; tick(2); chk(1'b0, "R9 new delay waits");
    tick(1); chk(1'b1, "R9 new delay completes");
  endtask

  initial begin
    tick(3);
    t_on_delay();
    t_abort();
    t_off_delay();
    t_init_on();
    t_init_off();
    t_zero();
    t_cfg_freeze();
    tick(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule